// File: doc/BRIEF.md
# Bus Clock-Enable Prescaler with Domain Gating

This block runs entirely on one system clock. From that clock it produces single-cycle enable strobes for a high-speed bus and for three peripheral buses. No derived clocks are generated. The high-speed strobe fires once every N system cycles. Each peripheral strobe fires once every M high-speed strobes, so it always coincides with a high-speed strobe. Logic downstream qualifies its flops with these strobes and stays in the system clock domain.

A small synchronous register port holds the ratio codes and the gate bits.

- The high-speed ratio code is 4 bits. It uses a power-of-two map that jumps from 16 straight to 64.
- Each peripheral code is 3 bits.
- There are three high-speed domain outputs and three peripheral outputs. Each has its own gate bit.
- A dedicated watchdog strobe is tapped from the first peripheral bus. It keeps running when that bus is gated.

Ratio changes never cut a period short. A new high-speed ratio is adopted at the next high-speed strobe. A new peripheral ratio is adopted at that bus's next strobe. When the high-speed ratio changes, the peripheral counters restart at the strobe where the change lands.

Top module: `bgp_top`

## Requirements
- R1: While reset is asserted, all enable outputs are low and the readback is zero. After reset every field is zero, so every output strobes on every system cycle.
- R2: The high-speed period in system cycles is 1 for codes 0-7. It is 2, 4, 8 and 16 for codes 8-11, and 64, 128, 256 and 512 for codes 12-15. The code sits in bits 3:0.
- R3: A peripheral period in high-speed strobes is 1 for codes 0-3 and 2, 4, 8, 16 for codes 4-7. The code for bus j sits in bits 4j+6:4j+4.
- R4: Every peripheral strobe coincides with a high-speed strobe. A peripheral period in system cycles therefore equals the high-speed period times the peripheral period.
- R5: A new peripheral code is adopted at that bus's next strobe. The interval that ends at that strobe keeps the old length, which is at most 16 high-speed strobes. The interval after it has the new length.
- R6: A new high-speed code is adopted at the next high-speed strobe, and the interval ending there keeps the old length. At that strobe all peripheral counters restart from zero, so the first peripheral strobe follows M new high-speed strobes later.
- R7: Gate bit 16+i set to 1 holds high-speed output i low. Set to 0, it passes the strobe. The other outputs are not affected.
- R8: Gate bit 20+j set to 1 holds peripheral output j low. Set to 0, it passes the strobe.
- R9: The watchdog output follows peripheral bus 0's strobe whatever the value of bit 20.
- R10: The readback returns every field at its written position. All other bits read zero, so writing all ones reads back 0x0077777F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register readback |
| hs_en | output | NUM_HS | Gated high-speed domain enable strobes |
| pb_en | output | NUM_PB | Gated peripheral bus enable strobes |
| wdg_en | output | 1 | Ungated watchdog strobe from peripheral bus 0 |

## Verification
A wrong counter value or a wrong adopted ratio shows up at the ports as a strobe interval of the wrong length. It appears within one period of the affected output, so at most 512 system cycles for the high-speed strobe and 8192 for a peripheral strobe. Each of the following changes the length of the first or second interval after a write by at least one cycle:

- a ratio that is adopted too early or too late;
- a missing peripheral restart on a high-speed change.

For that reason these intervals are measured edge-to-edge. A broken gate or readback field shows in the very next sampled cycle.

// File: rtl/bgp_pkg.sv
package bgp_pkg;

   localparam int HS_CODE_W    = 4;
   localparam int PB_CODE_W    = 3;
   localparam int HS_SHIFT_W   = 4;
   localparam int PB_SHIFT_W   = 3;
   localparam int HS_MAX_SHIFT = 9;
   localparam int PB_MAX_SHIFT = 4;
   localparam int FIELD_STRIDE = 4;
   localparam int HS_CODE_LSB  = 0;
   localparam int PB_CODE_LSB  = 4;

   function automatic int hs_dis_lsb(input int npb);
      return PB_CODE_LSB + FIELD_STRIDE * npb;
   endfunction

   function automatic int pb_dis_lsb(input int nhs, input int npb);
      return hs_dis_lsb(npb) + FIELD_STRIDE * ((nhs + FIELD_STRIDE - 1) / FIELD_STRIDE);
   endfunction

   function automatic int used_width(input int nhs, input int npb);
      return pb_dis_lsb(nhs, npb) + npb;
   endfunction

   // high-speed code -> log2 of the ratio; 32 is skipped
   function automatic logic [HS_SHIFT_W-1:0] hs_code_shift(input logic [HS_CODE_W-1:0] c);
      logic [HS_SHIFT_W-1:0] s;
      if (!c[3])      s = '0;
      else if (!c[2]) s = {2'b00, c[1:0]} + 4'd1;
      else            s = {1'b0, c[2:0]} + 4'd2;
      return s;
   endfunction

   function automatic logic [PB_SHIFT_W-1:0] pb_code_shift(input logic [PB_CODE_W-1:0] c);
      logic [PB_SHIFT_W-1:0] s;
      if (!c[2]) s = '0;
      else       s = {1'b0, c[1:0]} + 3'd1;
      return s;
   endfunction

endpackage

// File: rtl/bgp_regs.sv
module bgp_regs
   import bgp_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int NUM_HS = 3,
   parameter int NUM_PB = 3
)(
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   wr_en,
   input  logic [DATA_W-1:0]                      wr_data,
   output logic [HS_CODE_W-1:0]                   hs_code,
   output logic [NUM_PB-1:0][PB_CODE_W-1:0]       pb_code,
   output logic [NUM_HS-1:0]                      hs_dis,
   output logic [NUM_PB-1:0]                      pb_dis,
   output logic [DATA_W-1:0]                      rd_data
);
   localparam int HSD_LSB = hs_dis_lsb(NUM_PB);
   localparam int PBD_LSB = pb_dis_lsb(NUM_HS, NUM_PB);
   localparam int USED_W  = used_width(NUM_HS, NUM_PB);

   if (DATA_W < USED_W) begin : g_bad_width
      $error("bgp_regs: DATA_W too small for the field layout");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_code <= '0;
         pb_code <= '0;
         hs_dis  <= '0;
         pb_dis  <= '0;
      end else if (wr_en) begin
         hs_code <= wr_data[HS_CODE_LSB +: HS_CODE_W];
         for (int j = 0; j < NUM_PB; j++)
            pb_code[j] <= wr_data[PB_CODE_LSB + FIELD_STRIDE*j +: PB_CODE_W];
         hs_dis  <= wr_data[HSD_LSB +: NUM_HS];
         pb_dis  <= wr_data[PBD_LSB +: NUM_PB];
      end
   end

   always_comb begin
      rd_data = '0;
      rd_data[HS_CODE_LSB +: HS_CODE_W] = hs_code;
      for (int j = 0; j < NUM_PB; j++)
         rd_data[PB_CODE_LSB + FIELD_STRIDE*j +: PB_CODE_W] = pb_code[j];
      rd_data[HSD_LSB +: NUM_HS] = hs_dis;
      rd_data[PBD_LSB +: NUM_PB] = pb_dis;
   end

endmodule

// File: rtl/bgp_hs_div.sv
module bgp_hs_div #(
   parameter int SHIFT_W   = 4,
   parameter int MAX_SHIFT = 9,
   parameter int CNT_W     = 9
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SHIFT_W-1:0] shift_req,
   output logic               tick,
   output logic               ratio_switch
);
   if (CNT_W < MAX_SHIFT) begin : g_bad_cnt
      $error("bgp_hs_div: counter narrower than the largest ratio");
   end

   logic               run_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [CNT_W-1:0]   lim;
   logic [SHIFT_W-1:0] act_q;

   always_comb lim = CNT_W'((32'd1 << act_q) - 32'd1);

   assign tick         = run_q && (cnt_q == lim);
   assign ratio_switch = tick && (shift_req != act_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         act_q <= '0;
      end else begin
         run_q <= 1'b1;
         if (tick) begin
            cnt_q <= '0;
            act_q <= shift_req;
         end else if (run_q) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/bgp_pb_div.sv
module bgp_pb_div #(
   parameter int SHIFT_W   = 3,
   parameter int MAX_SHIFT = 4,
   parameter int CNT_W     = 4
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hs_tick,
   input  logic               restart,
   input  logic [SHIFT_W-1:0] shift_req,
   output logic               tick
);
   if (CNT_W < MAX_SHIFT) begin : g_bad_cnt
      $error("bgp_pb_div: counter narrower than the largest ratio");
   end

   logic [CNT_W-1:0]   cnt_q;
   logic [CNT_W-1:0]   lim;
   logic [SHIFT_W-1:0] act_q;

   always_comb lim = CNT_W'((32'd1 << act_q) - 32'd1);

   assign tick = hs_tick && (cnt_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= '0;
      end else if (hs_tick) begin
         if (restart || tick) begin
            cnt_q <= '0;
            act_q <= shift_req;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/bgp_top.sv
module bgp_top
   import bgp_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int NUM_HS    = 3,
   parameter int NUM_PB    = 3,
   parameter int WDG_BUS   = 0,
   parameter bit HAS_WDG   = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic [NUM_HS-1:0] hs_en,
   output logic [NUM_PB-1:0] pb_en,
   output logic              wdg_en
);
   localparam int HS_CNT_W = HS_MAX_SHIFT;
   localparam int PB_CNT_W = PB_MAX_SHIFT;

   if (NUM_HS < 1 || NUM_PB < 1) begin : g_bad_count
      $error("bgp_top: need at least one bus of each kind");
   end
   if (WDG_BUS >= NUM_PB) begin : g_bad_wdg
      $error("bgp_top: watchdog tap outside the peripheral buses");
   end

   logic [HS_CODE_W-1:0]             hs_code;
   logic [NUM_PB-1:0][PB_CODE_W-1:0] pb_code;
   logic [NUM_HS-1:0]                hs_dis;
   logic [NUM_PB-1:0]                pb_dis;
   logic                             hs_tick;
   logic                             hs_switch;
   logic [NUM_PB-1:0]                pb_tick;
   logic [HS_SHIFT_W-1:0]            hs_shift;

   bgp_regs #(.DATA_W(DATA_W), .NUM_HS(NUM_HS), .NUM_PB(NUM_PB)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_data (cfg_wdata),
      .hs_code (hs_code),
      .pb_code (pb_code),
      .hs_dis  (hs_dis),
      .pb_dis  (pb_dis),
      .rd_data (cfg_rdata)
   );

   assign hs_shift = hs_code_shift(hs_code);

   bgp_hs_div #(.SHIFT_W(HS_SHIFT_W), .MAX_SHIFT(HS_MAX_SHIFT), .CNT_W(HS_CNT_W)) u_hs (
      .clk          (clk),
      .rst_n        (rst_n),
      .shift_req    (hs_shift),
      .tick         (hs_tick),
      .ratio_switch (hs_switch)
   );

   for (genvar j = 0; j < NUM_PB; j++) begin : g_pb
      logic [PB_SHIFT_W-1:0] pb_shift;
      assign pb_shift = pb_code_shift(pb_code[j]);
      bgp_pb_div #(.SHIFT_W(PB_SHIFT_W), .MAX_SHIFT(PB_MAX_SHIFT), .CNT_W(PB_CNT_W)) u_div (
         .clk       (clk),
         .rst_n     (rst_n),
         .hs_tick   (hs_tick),
         .restart   (hs_switch),
         .shift_req (pb_shift),
         .tick      (pb_tick[j])
      );
      assign pb_en[j] = pb_tick[j] & ~pb_dis[j];
   end

   for (genvar i = 0; i < NUM_HS; i++) begin : g_hs_gate
      assign hs_en[i] = hs_tick & ~hs_dis[i];
   end

   if (HAS_WDG) begin : g_wdg
      assign wdg_en = pb_tick[WDG_BUS];
   end else begin : g_no_wdg
      assign wdg_en = 1'b0;
   end

endmodule

// File: rtl/bgp_chk.sv
module bgp_chk
   import bgp_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int NUM_HS  = 3,
   parameter int NUM_PB  = 3,
   parameter int WDG_BUS = 0,
   parameter bit HAS_WDG = 1'b1
)(
   input logic              clk,
   input logic              rst_n,
   input logic              hs_tick,
   input logic              hs_switch,
   input logic [NUM_PB-1:0] pb_tick,
   input logic [NUM_HS-1:0] hs_en,
   input logic [NUM_PB-1:0] pb_en,
   input logic              wdg_en,
   input logic [DATA_W-1:0] cfg_rdata
);
   localparam int HSD_LSB = hs_dis_lsb(NUM_PB);
   localparam int PBD_LSB = pb_dis_lsb(NUM_HS, NUM_PB);

   logic [DATA_W-1:0] used_m;
   always_comb begin
      used_m = '0;
      used_m[HS_CODE_LSB +: HS_CODE_W] = '1;
      for (int j = 0; j < NUM_PB; j++)
         used_m[PB_CODE_LSB + FIELD_STRIDE*j +: PB_CODE_W] = '1;
      used_m[HSD_LSB +: NUM_HS] = '1;
      used_m[PBD_LSB +: NUM_PB] = '1;
   end

   // system cycles since the last high-speed strobe
   logic [9:0] hs_gap;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            hs_gap <= '0;
      else if (hs_tick)      hs_gap <= '0;
      else if (hs_gap != '1) hs_gap <= hs_gap + 1'b1;
   end

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |-> (hs_en == '0 && pb_en == '0 && !wdg_en && cfg_rdata == '0));

   p_hs_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hs_gap <= 10'd511);

   p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata & ~used_m) == '0);

   for (genvar j = 0; j < NUM_PB; j++) begin : g_pb_chk
      logic [4:0] pb_gap;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pb_gap <= '0;
         else if (hs_tick) begin
            if (pb_tick[j] || hs_switch) pb_gap <= '0;
            else if (pb_gap != '1)       pb_gap <= pb_gap + 1'b1;
         end
      end

      p_pb_subset_r4: assert property (@(posedge clk) disable iff (!rst_n)
         pb_tick[j] |-> hs_tick);

      p_pb_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
         pb_gap <= 5'd15);

      p_pb_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_rdata[PBD_LSB + j] |-> !pb_en[j]);
   end

   for (genvar i = 0; i < NUM_HS; i++) begin : g_hs_chk
      p_hs_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_rdata[HSD_LSB + i] |-> !hs_en[i]);
   end

   if (HAS_WDG) begin : g_wdg_chk
      p_wdg_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !cfg_rdata[PBD_LSB + WDG_BUS] |-> (wdg_en == pb_en[WDG_BUS]));
   end

endmodule

bind bgp_top bgp_chk #(
   .DATA_W  (DATA_W),
   .NUM_HS  (NUM_HS),
   .NUM_PB  (NUM_PB),
   .WDG_BUS (WDG_BUS),
   .HAS_WDG (HAS_WDG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hs_tick   (hs_tick),
   .hs_switch (hs_switch),
   .pb_tick   (pb_tick),
   .hs_en     (hs_en),
   .pb_en     (pb_en),
   .wdg_en    (wdg_en),
   .cfg_rdata (cfg_rdata)
);

// File: tb/bgp_top_bench.sv
module bgp_top_bench;
   localparam int CLK_P = 10;
   localparam int LIMIT = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [2:0]  hs_en;
   logic [2:0]  pb_en;
   logic        wdg_en;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   bgp_top u_bgp_top (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .hs_en(hs_en), .pb_en(pb_en), .wdg_en(wdg_en)
   );

   function automatic int exp_hs(input int c);
      case (c)
         8: return 2;    9: return 4;    10: return 8;   11: return 16;
         12: return 64;  13: return 128; 14: return 256; 15: return 512;
         default: return 1;
      endcase
   endfunction

   function automatic int exp_pb(input int c);
      case (c)
         4: return 2; 5: return 4; 6: return 8; 7: return 16;
         default: return 1;
      endcase
   endfunction

   function automatic logic [31:0] mk(input int hs, input int p0, input int p1,
                                      input int p2, input int hsd, input int pbd);
      return {9'b0, pbd[2:0], 1'b0, hsd[2:0], 1'b0, p2[2:0], 1'b0, p1[2:0],
              1'b0, p0[2:0], hs[3:0]};
   endfunction

   // sel 0: hs_en[idx], 1: pb_en[idx], 2: wdg_en
   function automatic logic sig(input int sel, input int idx);
      if (sel == 0) return hs_en[idx];
      if (sel == 1) return pb_en[idx];
      return wdg_en;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      cfg_wdata = d;
      cfg_we    = 1'b1;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   // cycles to the next high sample, -1 on timeout
   task automatic next_high(input int sel, input int idx, output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!sig(sel, idx) && n < LIMIT);
      if (!sig(sel, idx)) n = -1;
   endtask

   task automatic measure(input int sel, input int idx, output int per);
      int t;
      for (int k = 0; k < 3; k++) next_high(sel, idx, t);
      next_high(sel, idx, per);
   endtask

   task automatic gap_after_write(input int sel, input int idx,
                                  input logic [31:0] d, output int n);
      cfg_wdata = d;
      cfg_we    = 1'b1;
      @(negedge clk);
      cfg_we    = 1'b0;
      n = 1;
      while (!sig(sel, idx) && n < LIMIT) begin
         @(negedge clk);
         n++;
      end
      if (!sig(sel, idx)) n = -1;
   endtask

   task automatic count_pulses(input int sel, input int idx, input int win, output int c);
      c = 0;
      for (int k = 0; k < win; k++) begin
         @(negedge clk);
         if (sig(sel, idx)) c++;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int p, g, c;
      int hs, p0, p1, p2;
      void'($urandom(32'h5EED_1234));

      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 rdata in reset", int'(cfg_rdata), 0);
      chk("R1 hs_en in reset", int'(hs_en), 0);
      chk("R1 pb_en in reset", int'(pb_en), 0);
      chk("R1 wdg_en in reset", int'(wdg_en), 0);
      rst_n = 1'b1;
      measure(0, 0, p); chk("R1 hs period after reset", p, 1);
      measure(1, 2, p); chk("R1 pb period after reset", p, 1);
      count_pulses(0, 1, 20, c); chk("R1 hs_en1 every cycle", c, 20);

      // R10 readback
      wr(32'hFFFF_FFFF);
      chk("R10 all ones readback", int'(cfg_rdata), int'(32'h0077_777F));
      wr(32'hA5C3_96E1);
      chk("R10 pattern readback", int'(cfg_rdata), int'(32'hA5C3_96E1 & 32'h0077_777F));
      wr(mk(3, 5, 6, 7, 2, 5));
      chk("R10 field positions", int'(cfg_rdata), int'(mk(3, 5, 6, 7, 2, 5)));
      wr(32'h0);

      // R2 every high-speed code, R4 pb at ratio 1 follows hs
      for (int k = 0; k < 16; k++) begin
         wr(mk(k, 0, 0, 0, 0, 0));
         measure(0, k % 3, p); chk($sformatf("R2 hs code %0d", k), p, exp_hs(k));
         if (k == 15 || k == 11) begin
            measure(1, 1, p); chk($sformatf("R4 pb1 at hs code %0d", k), p, exp_hs(k));
         end
      end

      // R3 every peripheral code on every bus
      for (int j = 0; j < 3; j++) begin
         for (int k = 0; k < 8; k++) begin
            wr(mk(0, (j == 0) ? k : 0, (j == 1) ? k : 0, (j == 2) ? k : 0, 0, 0));
            measure(1, j, p); chk($sformatf("R3 bus %0d code %0d", j, k), p, exp_pb(k));
         end
      end

      // R4 product of ratios
      wr(mk(9, 0, 6, 7, 0, 0));
      measure(1, 1, p); chk("R4 hs4 x pb8", p, 32);
      measure(1, 2, p); chk("R4 hs4 x pb16", p, 64);
      measure(1, 0, p); chk("R4 hs4 x pb1", p, 4);

      // R5 peripheral update latency
      wr(mk(0, 7, 0, 0, 0, 0));
      measure(2, 0, p); chk("R5 settle pb0 ratio 16", p, 16);
      gap_after_write(2, 0, mk(0, 5, 0, 0, 0, 0), g); chk("R5 gap keeps old 16", g, 16);
      next_high(2, 0, g); chk("R5 new ratio 4", g, 4);
      gap_after_write(2, 0, mk(0, 0, 0, 0, 0, 0), g); chk("R5 gap keeps old 4", g, 4);
      next_high(2, 0, g); chk("R5 new ratio 1", g, 1);

      // R6 high-speed update and peripheral restart
      wr(mk(9, 0, 0, 0, 0, 0));
      measure(0, 0, p); chk("R6 settle hs 4", p, 4);
      gap_after_write(0, 0, mk(8, 0, 0, 0, 0, 0), g); chk("R6 hs gap keeps old 4", g, 4);
      next_high(0, 0, g); chk("R6 hs new ratio 2", g, 2);
      wr(mk(8, 6, 0, 0, 0, 0));
      measure(2, 0, p); chk("R6 settle pb0 16", p, 16);
      gap_after_write(2, 0, mk(0, 6, 0, 0, 0, 0), g); chk("R6 restart gap", g, 10);
      next_high(2, 0, g); chk("R6 pb0 after restart", g, 8);

      // R7 R8 R9 gating
      wr(mk(0, 0, 0, 0, 5, 3));
      count_pulses(0, 0, 50, c); chk("R7 hs_en0 gated", c, 0);
      count_pulses(0, 1, 50, c); chk("R7 hs_en1 passes", c, 50);
      count_pulses(0, 2, 50, c); chk("R7 hs_en2 gated", c, 0);
      count_pulses(1, 0, 50, c); chk("R8 pb_en0 gated", c, 0);
      count_pulses(1, 1, 50, c); chk("R8 pb_en1 gated", c, 0);
      count_pulses(1, 2, 50, c); chk("R8 pb_en2 passes", c, 50);
      count_pulses(2, 0, 50, c); chk("R9 wdg runs while bus0 gated", c, 50);
      wr(mk(0, 5, 0, 0, 0, 1));
      measure(2, 0, p); chk("R9 wdg period 4 while gated", p, 4);
      count_pulses(1, 0, 64, c); chk("R8 pb_en0 stays low", c, 0);
      wr(mk(0, 5, 0, 0, 0, 0));
      count_pulses(1, 0, 64, c); chk("R8 pb_en0 released", c, 16);
      count_pulses(0, 0, 30, c); chk("R7 hs_en0 released", c, 30);

      // random mix R2 R3 R4
      for (int it = 0; it < 12; it++) begin
         hs = int'($urandom % 12);
         p0 = int'($urandom % 8);
         p1 = int'($urandom % 8);
         p2 = int'($urandom % 8);
         wr(mk(hs, p0, p1, p2, 0, 0));
         measure(0, int'($urandom % 3), p); chk("R2 random hs", p, exp_hs(hs));
         measure(1, 0, p); chk("R4 random pb0", p, exp_hs(hs) * exp_pb(p0));
         measure(1, 1, p); chk("R4 random pb1", p, exp_hs(hs) * exp_pb(p1));
         measure(1, 2, p); chk("R4 random pb2", p, exp_hs(hs) * exp_pb(p2));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule